// File: doc/BRIEF.md
# Planar Graphics Write Datapath

This block connects a byte-wide CPU port to four 8-bit video memory planes that share one address. Every CPU read fetches the byte at that address from all four planes at once. It keeps the four bytes in a 32-bit latch and returns one byte to the CPU. Every CPU write turns a single CPU byte into four plane bytes. It does so through a programmable right-rotate, a per-plane colour substitution, a logical operation against the latch and a bit-position mask. The result is written to the planes that the plane-enable mask selects. To change a few pixels, software reads an address to fill the latch and then writes the same address. Only the masked bit positions change, and the rest are restored from the latch.

Configuration uses an index/data pair. A write with `reg_sel` = 0 stores the register index. A write with `reg_sel` = 1 stores the data byte into the register that index selects. Each plane is a plain synchronous RAM outside the block with a read latency of one cycle. The CPU issues one access at a time and waits for `cpu_rvalid` after a read before it issues the next access.

Top module: `planar_gfx_wr`

## Requirements
- R1: A CPU read raises `mem_rd` one cycle later. Two cycles after that, `cpu_rvalid` pulses for one cycle, and all four returned plane bytes are held in the latch (plane p in bits 8p+7:8p). With the read mode (mode register, index 0, bit 3) at 0, `cpu_rdata` is the byte of the plane chosen by the read-plane register (index 6, bits 1:0).
- R2: With the read mode at 1, bit i of `cpu_rdata` is 1 when every plane p that is set in the compare-mask register (index 8, bits 3:0) has bit i equal to bit p of the compare-colour register (index 7).
- R3: In write mode 0 (mode register bits 1:0 = 0), plane p takes the CPU byte rotated right by the count in the rotate register (index 1, bits 2:0). If bit p of the substitute-enable register (index 5) is set, plane p takes instead the byte filled with bit p of the colour register (index 4).
- R4: Rotate register bits 4:3 pick the operation between the source byte and the latch byte of that plane: 0 passes the source, 1 AND, 2 OR, 3 XOR.
- R5: Bit positions where the bit-mask register (index 2) is 0 take the latched value in every write mode except 1. A read-modify-write that uses colour substitution on all planes therefore gives the same result for any CPU byte.
- R6: In write mode 1, each plane receives its latch byte unchanged, and rotate, operation and mask have no effect.
- R7: In write mode 2, bit p of the CPU byte is expanded to 0x00 or 0xFF as the source of plane p. The operation and the mask then apply.
- R8: In write mode 3, the source of plane p is the byte filled with colour bit p. The effective mask is the rotated CPU byte ANDed with the bit-mask register.
- R9: Only planes set in the plane-enable register (index 3, bits 3:0) are written. A write appears on the memory port one cycle after the CPU write, with `mem_be` equal to that register.
- R10: After reset the bit mask is 0xFF, the plane enable and the compare mask are 0x0F, all other registers and the latch are zero, and no memory access is in progress.
- R11: A data write goes to the register selected by the last index written. A data write to an index above 8 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_sel | input | 1 | 0 = index register, 1 = data register |
| reg_wdata | input | 8 | Configuration write byte |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read result |
| cpu_rvalid | output | 1 | Read result valid pulse |
| mem_rd | output | 1 | Plane read strobe |
| mem_wr | output | 1 | Plane write strobe |
| mem_addr | output | AW | Plane address |
| mem_wdata | output | 32 | Plane write bytes, plane p in bits 8p+7:8p |
| mem_be | output | 4 | Per-plane write enables |
| mem_rdata | input | 32 | Plane read bytes, one cycle after mem_rd |

## Verification
The hardest state to reach is a write whose outcome depends on the latch. The bit mask, the operation, the latch-copy mode and the masked mode all depend on it, and the latch cannot be seen at the ports. It only fills through a prior read of memory that the bench has already shaped. The stimulus therefore seeds the planes with known bytes and interleaves random reads, writes and register updates. This way every write meets a latch loaded from a different address than the one being written. Directed sequences also repeat a read-modify-write with opposite CPU bytes to show that the CPU byte has no influence.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = PLANES * BYTE_W;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {
    WM_COMBINE = 2'd0,
    WM_LATCH   = 2'd1,
    WM_EXPAND  = 2'd2,
    WM_MASKED  = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XOR  = 2'd3
  } aluop_e;

  localparam logic [IDX_W-1:0] IX_MODE    = 4'd0;
  localparam logic [IDX_W-1:0] IX_ROTOP   = 4'd1;
  localparam logic [IDX_W-1:0] IX_BITMASK = 4'd2;
  localparam logic [IDX_W-1:0] IX_PLANEEN = 4'd3;
  localparam logic [IDX_W-1:0] IX_COLOUR  = 4'd4;
  localparam logic [IDX_W-1:0] IX_SUBEN   = 4'd5;
  localparam logic [IDX_W-1:0] IX_RDPLANE = 4'd6;
  localparam logic [IDX_W-1:0] IX_CMPCOL  = 4'd7;
  localparam logic [IDX_W-1:0] IX_CMPMASK = 4'd8;

  typedef struct packed {
    wmode_e              wmode;
    logic                rmode;
    logic [2:0]          rot;
    aluop_e              op;
    logic [BYTE_W-1:0]   bitmask;
    logic [PLANES-1:0]   plane_en;
    logic [PLANES-1:0]   colour;
    logic [PLANES-1:0]   sub_en;
    logic [1:0]          rd_plane;
    logic [PLANES-1:0]   cmp_col;
    logic [PLANES-1:0]   cmp_mask;
  } gfx_cfg_t;

  function automatic logic [BYTE_W-1:0] rotr8(input logic [BYTE_W-1:0] v,
                                              input logic [2:0] n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/gfx_regs.sv
module gfx_regs
  import gfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output gfx_cfg_t          cfg
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q        <= '0;
      cfg.wmode    <= WM_COMBINE;
      cfg.rmode    <= 1'b0;
      cfg.rot      <= '0;
      cfg.op       <= OP_PASS;
      cfg.bitmask  <= '1;
      cfg.plane_en <= '1;
      cfg.colour   <= '0;
      cfg.sub_en   <= '0;
      cfg.rd_plane <= '0;
      cfg.cmp_col  <= '0;
      cfg.cmp_mask <= '1;
    end else if (reg_wr && !reg_sel) begin
      idx_q <= reg_wdata[IDX_W-1:0];
    end else if (reg_wr && reg_sel) begin
      case (idx_q)
        IX_MODE: begin
          cfg.wmode <= wmode_e'(reg_wdata[1:0]);
          cfg.rmode <= reg_wdata[3];
        end
        IX_ROTOP: begin
          cfg.rot <= reg_wdata[2:0];
          cfg.op  <= aluop_e'(reg_wdata[4:3]);
        end
        IX_BITMASK: cfg.bitmask  <= reg_wdata;
        IX_PLANEEN: cfg.plane_en <= reg_wdata[PLANES-1:0];
        IX_COLOUR:  cfg.colour   <= reg_wdata[PLANES-1:0];
        IX_SUBEN:   cfg.sub_en   <= reg_wdata[PLANES-1:0];
        IX_RDPLANE: cfg.rd_plane <= reg_wdata[1:0];
        IX_CMPCOL:  cfg.cmp_col  <= reg_wdata[PLANES-1:0];
        IX_CMPMASK: cfg.cmp_mask <= reg_wdata[PLANES-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gfx_plane_alu.sv
module gfx_plane_alu
  import gfx_pkg::*;
(
  input  wmode_e            wmode,
  input  aluop_e            op,
  input  logic [BYTE_W-1:0] rot_cpu,
  input  logic              cpu_bit,
  input  logic              colour_bit,
  input  logic              sub_bit,
  input  logic [BYTE_W-1:0] bitmask,
  input  logic [BYTE_W-1:0] latch_byte,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] src, alu, eff_mask;

  always_comb begin
    case (wmode)
      WM_COMBINE: src = sub_bit ? {BYTE_W{colour_bit}} : rot_cpu;
      WM_EXPAND:  src = {BYTE_W{cpu_bit}};
      WM_MASKED:  src = {BYTE_W{colour_bit}};
      default:    src = latch_byte;
    endcase

    case (op)
      OP_AND:  alu = src & latch_byte;
      OP_OR:   alu = src | latch_byte;
      OP_XOR:  alu = src ^ latch_byte;
      default: alu = src;
    endcase

    eff_mask = (wmode == WM_MASKED) ? (rot_cpu & bitmask) : bitmask;

    if (wmode == WM_LATCH) out_byte = latch_byte;
    else                   out_byte = (alu & eff_mask) | (latch_byte & ~eff_mask);
  end
endmodule

// File: rtl/gfx_read_path.sv
module gfx_read_path
  import gfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issued,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              rmode,
  input  logic [1:0]        rd_plane,
  input  logic [PLANES-1:0] cmp_col,
  input  logic [PLANES-1:0] cmp_mask,
  output logic [BUS_W-1:0]  latch_q,
  output logic [BYTE_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic              ret_q;
  logic [BYTE_W-1:0] cmp_byte;
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      cmp_byte[i] = 1'b1;
      for (int p = 0; p < PLANES; p++) begin
        if (cmp_mask[p] && (mem_rdata[p*BYTE_W+i] != cmp_col[p]))
          cmp_byte[i] = 1'b0;
      end
    end
    sel_byte = mem_rdata[rd_plane*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q    <= 1'b0;
      latch_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      ret_q    <= rd_issued;
      rvalid_q <= ret_q;
      if (ret_q) begin
        latch_q <= mem_rdata;
        rdata_q <= rmode ? cmp_byte : sel_byte;
      end
    end
  end
endmodule

// File: rtl/planar_gfx_wr.sv
module planar_gfx_wr
  import gfx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          cpu_rvalid,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata
);
  gfx_cfg_t          cfg;
  logic [BUS_W-1:0]  latch_q;
  logic [BUS_W-1:0]  wr_bytes;
  logic [BYTE_W-1:0] rot_cpu;
  logic [PLANES-1:0] plane_en;
  logic [BYTE_W-1:0] bitmask;
  wmode_e            wmode;

  assign plane_en = cfg.plane_en;
  assign bitmask  = cfg.bitmask;
  assign wmode    = cfg.wmode;
  assign rot_cpu  = rotr8(cpu_wdata, cfg.rot);

  gfx_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cfg       (cfg)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    gfx_plane_alu u_alu (
      .wmode      (cfg.wmode),
      .op         (cfg.op),
      .rot_cpu    (rot_cpu),
      .cpu_bit    (cpu_wdata[p]),
      .colour_bit (cfg.colour[p]),
      .sub_bit    (cfg.sub_en[p]),
      .bitmask    (cfg.bitmask),
      .latch_byte (latch_q[p*BYTE_W +: BYTE_W]),
      .out_byte   (wr_bytes[p*BYTE_W +: BYTE_W])
    );
  end

  gfx_read_path u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_issued (mem_rd),
    .mem_rdata (mem_rdata),
    .rmode     (cfg.rmode),
    .rd_plane  (cfg.rd_plane),
    .cmp_col   (cfg.cmp_col),
    .cmp_mask  (cfg.cmp_mask),
    .latch_q   (latch_q),
    .rdata_q   (cpu_rdata),
    .rvalid_q  (cpu_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_rd <= cpu_rd;
      mem_wr <= cpu_wr && !cpu_rd;
      if (cpu_rd || cpu_wr) mem_addr <= cpu_addr;
      if (cpu_wr && !cpu_rd) begin
        mem_wdata <= wr_bytes;
        mem_be    <= plane_en;
      end
    end
  end
endmodule

// File: rtl/gfx_wr_chk.sv
module gfx_wr_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_rd,
  input logic        cpu_rvalid,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [31:0] latch_q,
  input logic [3:0]  plane_en,
  input logic [7:0]  bitmask,
  input logic [1:0]  wmode
);
  // R1
  rd_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_rd) |-> mem_rd);
  // R1
  rvalid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(mem_rd, 2));
  // R9
  plane_en_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_be == $past(plane_en)));
  // R6
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(wmode) == 2'd1) |-> (mem_wdata == $past(latch_q)));
  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(wmode) != 2'd1) |->
      (((mem_wdata ^ $past(latch_q)) & ~{4{$past(bitmask)}}) == 32'd0));
  // R1
  no_dual_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind planar_gfx_wr gfx_wr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_rd     (cpu_rd),
  .cpu_rvalid (cpu_rvalid),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .latch_q    (latch_q),
  .plane_en   (plane_en),
  .bitmask    (bitmask),
  .wmode      (wmode)
);

// File: tb/planar_gfx_wr_test.sv
module planar_gfx_wr_test;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          cpu_rvalid;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_be;
  logic [31:0]   mem_rdata = '0;

  always #2 clk = ~clk;

  planar_gfx_wr #(.AW(AW)) uut (.*);

  logic [7:0] ram [4][DEPTH];
  logic [7:0] ref_mem [4][DEPTH];

  always @(posedge clk) begin
    if (mem_wr)
      for (int p = 0; p < 4; p++)
        if (mem_be[p]) ram[p][mem_addr] <= mem_wdata[p*8 +: 8];
    if (mem_rd)
      mem_rdata <= {ram[3][mem_addr], ram[2][mem_addr], ram[1][mem_addr], ram[0][mem_addr]};
  end

  int n_chk = 0, n_bad = 0;

  // bench copy of the programmed state
  logic [1:0] m_wm; logic m_rm; logic [2:0] m_rot; logic [1:0] m_op;
  logic [7:0] m_bm; logic [3:0] m_pe, m_col, m_sub, m_cc, m_cm; logic [1:0] m_rp;
  logic [31:0] m_lat;
  logic [3:0]  m_idx;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] idx, logic [7:0] val);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = {4'd0, idx};
    @(negedge clk); reg_sel = 1; reg_wdata = val;
    @(negedge clk); reg_wr = 0; reg_sel = 0;
    m_idx = idx;
    case (idx)
      4'd0: begin m_wm = val[1:0]; m_rm = val[3]; end
      4'd1: begin m_rot = val[2:0]; m_op = val[4:3]; end
      4'd2: m_bm = val;
      4'd3: m_pe = val[3:0];
      4'd4: m_col = val[3:0];
      4'd5: m_sub = val[3:0];
      4'd6: m_rp = val[1:0];
      4'd7: m_cc = val[3:0];
      4'd8: m_cm = val[3:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] ror(logic [7:0] v, logic [2:0] n);
    logic [7:0] r = v;
    for (int k = 0; k < 8; k++) if (k < n) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [7:0] exp_byte(int p, logic [7:0] cpu, logic [7:0] lat);
    logic [7:0] rc = ror(cpu, m_rot);
    logic [7:0] s, a, m;
    if (m_wm == 2'd1) return lat;
    if (m_wm == 2'd0)      s = m_sub[p] ? (m_col[p] ? 8'hFF : 8'h00) : rc;
    else if (m_wm == 2'd2) s = cpu[p] ? 8'hFF : 8'h00;
    else                   s = m_col[p] ? 8'hFF : 8'h00;
    case (m_op)
      2'd1: a = s & lat;
      2'd2: a = s | lat;
      2'd3: a = s ^ lat;
      default: a = s;
    endcase
    m = (m_wm == 2'd3) ? (rc & m_bm) : m_bm;
    return (a & m) | (lat & ~m);
  endfunction

  function automatic string wtag();
    case (m_wm)
      2'd0: return "R3";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cpu_read(logic [AW-1:0] a, string tag);
    logic [7:0] e;
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0;
    @(negedge clk);
    @(negedge clk);
    m_lat = {ref_mem[3][a], ref_mem[2][a], ref_mem[1][a], ref_mem[0][a]};
    if (!m_rm) e = ref_mem[m_rp][a];
    else begin
      for (int i = 0; i < 8; i++) begin
        e[i] = 1'b1;
        for (int p = 0; p < 4; p++)
          if (m_cm[p] && ref_mem[p][a][i] != m_cc[p]) e[i] = 1'b0;
      end
    end
    check({tag, " rvalid"}, {31'd0, cpu_rvalid}, 32'd1);
    check(tag, {24'd0, cpu_rdata}, {24'd0, e});
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [7:0] d, string tag);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    for (int p = 0; p < 4; p++)
      if (m_pe[p]) ref_mem[p][a] = exp_byte(p, d, m_lat[p*8 +: 8]);
    @(negedge clk); cpu_wr = 0;
    @(negedge clk);
    check(tag, {ram[3][a], ram[2][a], ram[1][a], ram[0][a]},
               {ref_mem[3][a], ref_mem[2][a], ref_mem[1][a], ref_mem[0][a]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < DEPTH; i++) begin
        ram[p][i] = 8'($urandom);
        ref_mem[p][i] = ram[p][i];
      end
    m_wm = 0; m_rm = 0; m_rot = 0; m_op = 0; m_bm = 8'hFF; m_pe = 4'hF;
    m_col = 0; m_sub = 0; m_cc = 0; m_cm = 4'hF; m_rp = 0; m_lat = 0; m_idx = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: idle after reset, defaults pass CPU byte to all planes
    check("R10 idle", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R10 rvalid", {31'd0, cpu_rvalid}, 32'd0);
    cpu_write(8'h00, 8'hA5, "R10 defaults");
    check("R10 bytes", {ram[3][0], ram[2][0], ram[1][0], ram[0][0]}, 32'hA5A5A5A5);

    // R1: read each plane
    for (int p = 0; p < 4; p++) begin
      reg_write(4'd6, 8'(p));
      cpu_read(8'h10, "R1");
    end
    // R2: compare read
    reg_write(4'd0, 8'h08); reg_write(4'd7, 8'h05); reg_write(4'd8, 8'h0B);
    cpu_read(8'h11, "R2");
    reg_write(4'd0, 8'h00);

    // R3: rotate + substitution
    reg_write(4'd1, 8'h03); reg_write(4'd5, 8'h06); reg_write(4'd4, 8'h02);
    cpu_read(8'h20, "R1");
    cpu_write(8'h21, 8'h81, "R3");
    // R4: each logical operation
    reg_write(4'd5, 8'h00);
    for (int o = 0; o < 4; o++) begin
      reg_write(4'd1, 8'(o << 3));
      cpu_read(8'h30, "R1");
      cpu_write(8'h31 + 8'(o), 8'h3C, "R4");
    end
    reg_write(4'd1, 8'h00);

    // R5: read-modify-write independent of CPU byte
    reg_write(4'd2, 8'h10); reg_write(4'd5, 8'h0F); reg_write(4'd4, 8'h09);
    cpu_read(8'h40, "R1");
    cpu_write(8'h40, 8'h00, "R5 cpu=00");
    cpu_read(8'h41, "R1");
    ref_mem[0][8'h41] = ref_mem[0][8'h40]; ref_mem[1][8'h41] = ref_mem[1][8'h40];
    ref_mem[2][8'h41] = ref_mem[2][8'h40]; ref_mem[3][8'h41] = ref_mem[3][8'h40];
    m_lat = {ref_mem[3][8'h40], ref_mem[2][8'h40], ref_mem[1][8'h40], ref_mem[0][8'h40]};
    // latch inside the block holds address 0x41 bytes; refresh from 0x40 instead
    cpu_read(8'h40, "R1");
    cpu_write(8'h41, 8'hFF, "R5 cpu=FF");
    check("R5 same", {ram[3][8'h41], ram[2][8'h41], ram[1][8'h41], ram[0][8'h41]},
                     {ram[3][8'h40], ram[2][8'h40], ram[1][8'h40], ram[0][8'h40]});
    reg_write(4'd2, 8'hFF); reg_write(4'd5, 8'h00);

    // R6: latch copy to another address
    reg_write(4'd0, 8'h01); reg_write(4'd2, 8'h0F);
    cpu_read(8'h50, "R1");
    cpu_write(8'h51, 8'h77, "R6");
    // R7, R8
    reg_write(4'd0, 8'h02);
    cpu_write(8'h52, 8'h0A, "R7");
    reg_write(4'd0, 8'h03); reg_write(4'd1, 8'h01); reg_write(4'd4, 8'h0C);
    cpu_write(8'h53, 8'hF0, "R8");
    reg_write(4'd0, 8'h00); reg_write(4'd1, 8'h00); reg_write(4'd2, 8'hFF);

    // R9: only planes 0 and 2 enabled
    reg_write(4'd3, 8'h05);
    cpu_write(8'h60, 8'h5A, "R9");
    reg_write(4'd3, 8'h0F);

    // R11: unused index leaves the bit mask unchanged
    reg_write(4'd2, 8'hF0);
    reg_write(4'd12, 8'h00);
    cpu_read(8'h70, "R1");
    cpu_write(8'h70, 8'hFF, "R11");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom_range(0, 9));
      logic [AW-1:0] a = AW'($urandom);
      if (k < 3) reg_write(4'($urandom_range(0, 9)), 8'($urandom));
      else if (k < 6) cpu_read(a, m_rm ? "R2" : "R1");
      else cpu_write(a, 8'($urandom), wtag());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule